// File: doc/BRIEF.md
# Switch Handshake Coordinate Sequencer

This block is the control sequencer for a slow-clocked demonstration board on which an operator enters a pair of 8-bit coordinates with eight data switches and one handshake toggle. It captures the first coordinate on a rising level of the toggle, requires the toggle to drop, and captures the second coordinate the same way. Once the second coordinate is released, the sequencer issues a one-cycle start pulse to an external compute unit. It then waits for that unit's done strobe.

When done arrives, both results are taken in. The first result appears on the LED byte. Raising the toggle switches the LED byte to the second result, and lowering it sends the sequencer back to wait for a new first coordinate. The switches are assumed to be already stable because the clock is slow, so the block has no debouncing. The reset switch is active low and works asynchronously.

Top module: `coord_handshake_seq`

## Requirements
- R1: While rst_n is 0, and on the first cycle after it is released, x_in, y_in and led are all zero and start is 0. The sequencer then waits for the first coordinate.
- R2: In the first-coordinate wait, a clock edge that samples hs_sw=1 copies data_sw into x_in. The new value is visible after that edge.
- R3: After a capture, data_sw is ignored and further edges with hs_sw held at 1 capture nothing. A new capture needs an edge that samples hs_sw=0 first.
- R4: After the release that follows the x_in capture, an edge that samples hs_sw=1 copies data_sw into y_in. x_in is left unchanged.
- R5: The edge that samples hs_sw=0 after the y_in capture raises start for exactly one cycle. Start is 0 at every other time.
- R6: led keeps its previous value (zero after reset) until done is sampled at 1 in the compute wait. The edge that samples done loads res_x into led, and at the same edge res_y is stored for later.
- R7: done sampled at 1 outside the compute wait has no effect on led.
- R8: While the first result is shown, an edge that samples hs_sw=1 loads the stored res_y into led.
- R9: While the second result is shown, an edge that samples hs_sw=0 returns the sequencer to the first-coordinate wait. led keeps the second result until the next done.
- R10: Pulling rst_n to 0 in any state clears the outputs and returns the sequencer to the first-coordinate wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Active-low asynchronous reset switch |
| data_sw | input | 8 | Coordinate data switches |
| hs_sw | input | 1 | Handshake toggle switch |
| res_x | input | 8 | First result from the compute unit |
| res_y | input | 8 | Second result from the compute unit |
| done | input | 1 | Compute-complete strobe |
| x_in | output | 8 | Latched first coordinate |
| y_in | output | 8 | Latched second coordinate |
| start | output | 1 | One-cycle compute request |
| led | output | 8 | Displayed result byte |

## Verification
The assertions assume that hs_sw and data_sw are clean and synchronous, and that each level is held for at least one clock edge. This is the slow-clock premise that replaces debouncing. They also assume that res_x and res_y are valid in the same cycle as done. The stimulus keeps to this by driving every input on the falling clock edge and holding each toggle level for at least one full cycle. It presents the result values only while done is high and scrambles them afterwards, so that a late sample would be caught. Random coordinates, results and compute latencies are mixed with directed stray-done pulses and a reset taken in the middle of a sequence.

// File: rtl/coord_handshake_seq.sv
module coord_handshake_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_sw,
  input  logic         hs_sw,
  input  logic [W-1:0] res_x,
  input  logic [W-1:0] res_y,
  input  logic         done,
  output logic [W-1:0] x_in,
  output logic [W-1:0] y_in,
  output logic         start,
  output logic [W-1:0] led
);

  typedef enum logic [2:0] {
    GET_X, REL_X, GET_Y, REL_Y, BUSY, SHOW_X, SHOW_Y
  } st_t;

  st_t          st;
  logic [W-1:0] y_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= GET_X;
      x_in   <= '0;
      y_in   <= '0;
      start  <= 1'b0;
      led    <= '0;
      y_hold <= '0;
    end else begin
      start <= 1'b0;
      case (st)
        GET_X:  if (hs_sw) begin x_in <= data_sw; st <= REL_X; end
        REL_X:  if (!hs_sw) st <= GET_Y;
        GET_Y:  if (hs_sw) begin y_in <= data_sw; st <= REL_Y; end
        REL_Y:  if (!hs_sw) begin start <= 1'b1; st <= BUSY; end
        BUSY:   if (done) begin led <= res_x; y_hold <= res_y; st <= SHOW_X; end
        SHOW_X: if (hs_sw) begin led <= y_hold; st <= SHOW_Y; end
        SHOW_Y: if (!hs_sw) st <= GET_X;
        default: st <= GET_X;
      endcase
    end
  end

endmodule

module coord_handshake_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hs_sw,
  input logic         done,
  input logic [W-1:0] x_in,
  input logic [W-1:0] y_in,
  input logic         start,
  input logic [W-1:0] led
);

  assert_x_needs_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in != $past(x_in)) |-> $past(hs_sw));

  assert_y_needs_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (y_in != $past(y_in)) |-> $past(hs_sw));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_start_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> !$past(hs_sw));

  assert_led_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (led != $past(led)) |-> ($past(done) || $past(hs_sw)));

  assert_led_quiet_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $stable(led));

endmodule

bind coord_handshake_seq coord_handshake_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_sw(hs_sw), .done(done),
  .x_in(x_in), .y_in(y_in), .start(start), .led(led)
);

// File: tb/coord_handshake_seq_tb.sv
module coord_handshake_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data_sw = '0;
  logic       hs_sw = 1'b0;
  logic [7:0] res_x = '0;
  logic [7:0] res_y = '0;
  logic       done = 1'b0;
  logic [7:0] x_in, y_in, led;
  logic       start;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] prev_led = '0;
  logic [7:0] prev_y = '0;

  always #5 clk = ~clk;

  coord_handshake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .data_sw(data_sw), .hs_sw(hs_sw),
    .res_x(res_x), .res_y(res_y), .done(done),
    .x_in(x_in), .y_in(y_in), .start(start), .led(led)
  );

  function automatic logic [7:0] ref_x(logic [7:0] a, logic [7:0] b);
    return a + (b << 1) + 8'd3;
  endfunction

  function automatic logic [7:0] ref_y(logic [7:0] a, logic [7:0] b);
    return (a ^ b) - 8'd7;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_pair(input logic [7:0] x, input logic [7:0] y, input int lat);
    logic [7:0] rx, ry;
    rx = ref_x(x, y);
    ry = ref_y(x, y);
    done = 1'b1; res_x = ~prev_led;
    tick;
    done = 1'b0;
    chk(led == prev_led, "R7 stray done before capture", led, prev_led);
    data_sw = x; hs_sw = 1'b1;
    tick;
    chk(x_in == x, "R2 x capture", x_in, x);
    data_sw = ~x;
    tick;
    chk(x_in == x, "R3 x held", x_in, x);
    chk(y_in == prev_y, "R3 no y while high", y_in, prev_y);
    hs_sw = 1'b0;
    tick;
    chk(start == 1'b0, "R5 no start early", start, 0);
    data_sw = y; hs_sw = 1'b1;
    tick;
    chk(y_in == y, "R4 y capture", y_in, y);
    chk(x_in == x, "R4 x unchanged", x_in, x);
    hs_sw = 1'b0; data_sw = ~y;
    tick;
    chk(start == 1'b1, "R5 start pulse", start, 1);
    chk(led == prev_led, "R6 led before done", led, prev_led);
    for (int i = 0; i < lat; i++) begin
      tick;
      chk(start == 1'b0, "R5 start single", start, 0);
      chk(led == prev_led, "R6 led waits", led, prev_led);
    end
    res_x = rx; res_y = ry; done = 1'b1;
    tick;
    done = 1'b0; res_x = ~rx; res_y = ~ry;
    chk(led == rx, "R6 x2 shown", led, rx);
    chk(start == 1'b0, "R5 start low", start, 0);
    done = 1'b1;
    tick;
    done = 1'b0;
    chk(led == rx, "R7 stray done while shown", led, rx);
    hs_sw = 1'b1;
    tick;
    chk(led == ry, "R8 y2 shown", led, ry);
    hs_sw = 1'b0;
    tick;
    chk(led == ry, "R9 y2 kept", led, ry);
    prev_led = ry;
    prev_y = y;
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick;
    chk(x_in == 0 && y_in == 0 && led == 0, "R1 reset outputs", {x_in, y_in, led}, 0);
    chk(start == 1'b0, "R1 reset start", start, 0);
    rst_n = 1'b1;
    tick;
    chk(led == 0 && start == 0, "R1 after release", led, 0);
    run_pair(8'h00, 8'h00, 0);
    run_pair(8'h7F, 8'h80, 1);
    run_pair(8'hFF, 8'h01, 3);
    for (int k = 0; k < 20; k++)
      run_pair(8'($urandom), 8'($urandom), int'($urandom % 5));
    data_sw = 8'h5C; hs_sw = 1'b1;
    tick;
    chk(x_in == 8'h5C, "R2 capture before reset", x_in, 8'h5C);
    hs_sw = 1'b0;
    tick;
    rst_n = 1'b0;
    tick;
    chk(x_in == 0 && y_in == 0 && led == 0 && start == 0, "R10 mid reset", {x_in, y_in, led}, 0);
    rst_n = 1'b1;
    tick;
    prev_led = '0; prev_y = '0;
    data_sw = 8'hA3; hs_sw = 1'b1;
    tick;
    chk(x_in == 8'hA3 && y_in == 8'h00, "R10 back to x wait", {x_in, y_in}, 16'hA300);
    hs_sw = 1'b0;
    tick;
    rst_n = 1'b0;
    tick;
    rst_n = 1'b1;
    tick;
    run_pair(8'h12, 8'h34, 2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule